// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a cycle-accurate model of a pipelined synchronous SRAM with a shared data bus. The array is small and parameterised: by default 256 words of 18 bits, split into two 9-bit lanes. Every control input is sampled at the rising clock edge. Read data passes through an output register, so it reaches the bus one edge after the access is issued. The output-enable input is the only input that acts without the clock.

There are two access strobes. The processor strobe always starts its access as a read, and it can turn into a write on the following edge. The controller strobe writes in the same edge it is sampled, if the write controls are active. A two-bit burst counter steps the word address inside an aligned group of four words. The order is linear by default, and a parameter selects the interleaved order.

A deselect keeps the last read data on the bus for one more cycle before the bus is released. Writes always release the bus, whatever output enable is doing.

Top module: `sync_burst_sram`

## Requirements
- R1: Define "selected" as `sel_a_n` low, `sel_b` high and `sel_c_n` low. A read starts at a rising edge when either strobe starts an access, the device is selected, and `wr_all_n` and `wr_lane_n` are both high. After the next rising edge, `rdata` holds that word and `rdata_oe` is high while `out_en_n` is low.
- R2: While `sel_a_n` is high, a low `cpu_strb_n` starts nothing. If `ctl_strb_n` is also high, the device carries on exactly as if both strobes were high.
- R3: An access started by `cpu_strb_n` ignores the write controls and `burst_adv_n` at its own edge and behaves as a read. At the next edge, with both strobes high and a write control active, the write goes to the loaded address, or to the stepped address if `burst_adv_n` is low.
- R4: An access started by `ctl_strb_n` alone, with the device selected and a write control low, writes `wdata` at that same edge to `addr`. `burst_adv_n` is ignored at that edge.
- R5: A low `wr_all_n` writes both lanes. Otherwise a low `wr_lane_n` writes only the lanes whose `lane_pick_n` bit is low: bit 0 controls `wdata[8:0]` and bit 1 controls `wdata[17:9]`. Lanes that are not written keep their contents.
- R6: In the cycle after any write edge, `rdata_oe` is low whatever the level of `out_en_n`.
- R7: A strobe sampled while the device is not selected is a deselect. Data from a read issued at the edge before the deselect is still driven after the deselect edge. `rdata_oe` goes low after the following edge.
- R8: When an access starts while the device is deselected, `rdata_oe` stays low for the cycle right after that edge.
- R9: `rdata_oe` follows `out_en_n` without waiting for a clock edge. It goes low as soon as `out_en_n` is high.
- R10: While an access is open, an edge with both strobes high continues it. A low `burst_adv_n` steps the two-bit counter, and a high one keeps the address. In linear order, the low address bits are the start value plus the count, modulo 4. The edge is a write if a write control is low, and a read otherwise.
- R11: While `rst_n` is low and after its release, `rdata_oe` is low and no access is open until a strobe starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low, gated by `sel_a_n` |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Burst step request, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_n | input | 1 | Write the picked lanes, active low |
| lane_pick_n | input | 2 | Per-lane write pick, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | 8 | Word address |
| wdata | input | 18 | Write data |
| rdata | output | 18 | Registered read data |
| rdata_oe | output | 1 | High when `rdata` drives the bus |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before the first access. They also assume that every control input is stable around each rising edge. The bench meets both conditions by driving all inputs only at the falling edge. Before any random traffic, it fills every address with a known pattern using controller-strobe writes, so no read can return an unwritten word. The random phase then mixes strobes, select levels, burst steps, lane masks and output-enable levels freely. Every such combination has a defined outcome, so the stimulus needs no further constraint beyond weighting the selects towards active.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   // Kind of access decided at a rising edge
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2,
      ACC_DESEL = 2'd3
   } acc_kind_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
   import sbs_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_strb_n,
   input  logic             ctl_strb_n,
   input  logic             burst_adv_n,
   input  logic             sel_a_n,
   input  logic             sel_b,
   input  logic             sel_c_n,
   input  logic             wr_all_n,
   input  logic             wr_lane_n,
   input  logic [LANES-1:0] lane_pick_n,
   output acc_kind_t        kind,
   output logic             load,
   output logic             step,
   output logic             active,
   output logic [LANES-1:0] lane_we
);
   if (LANES < 1) begin : g_bad_lanes
      $error("sbs_ctrl: LANES must be at least 1");
   end

   logic sel_all, p_go, c_go, wr_req;

   assign sel_all = !sel_a_n && sel_b && !sel_c_n;
   assign p_go    = !cpu_strb_n && !sel_a_n;
   assign c_go    = !ctl_strb_n;
   assign wr_req  = !wr_all_n || !wr_lane_n;

   always_comb begin
      kind = ACC_IDLE;
      load = 1'b0;
      step = 1'b0;
      if (rst_n) begin
         if (p_go || c_go) begin
            if (!sel_all) begin
               kind = ACC_DESEL;
            end else begin
               load = 1'b1;
               // the processor strobe never writes at its own edge
               kind = (!p_go && wr_req) ? ACC_WRITE : ACC_READ;
            end
         end else if (active) begin
            step = !burst_adv_n;
            kind = wr_req ? ACC_WRITE : ACC_READ;
         end
      end
   end

   always_comb begin
      lane_we = '0;
      if (kind == ACC_WRITE) begin
         if (!wr_all_n) lane_we = '1;
         else           lane_we = ~lane_pick_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 active <= 1'b0;
      else if (kind == ACC_DESEL) active <= 1'b0;
      else if (load)              active <= 1'b1;
   end

   AST_CPU_STRB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a_n && ctl_strb_n) |-> !load);                                 // R2
   AST_CPU_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_strb_n && !sel_a_n && load) |-> (kind == ACC_READ));          // R3
   AST_PICK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_all_n && !wr_lane_n) |-> ((lane_we & lane_pick_n) == '0));     // R5
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst #(
   parameter int AW      = 8,
   parameter int BW      = 2,
   parameter bit LINEAR  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_out
);
   if (BW < 1 || BW >= AW) begin : g_bad_bw
      $error("sbs_burst: BW must be in 1..AW-1");
   end

   logic [AW-1:0] base;
   logic [BW-1:0] cnt, cnt_use, low;

   assign cnt_use = step ? cnt + BW'(1) : cnt;

   if (LINEAR) begin : g_linear
      assign low = base[BW-1:0] + cnt_use;
   end else begin : g_interleave
      assign low = base[BW-1:0] ^ cnt_use;
   end

   assign addr_out = load ? addr_in : {base[AW-1:BW], low};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base <= '0;
         cnt  <= '0;
      end else if (load) begin
         base <= addr_in;
         cnt  <= '0;
      end else if (step) begin
         cnt  <= cnt_use;
      end
   end

   AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cnt == $past(cnt) + BW'(1)));                  // R10
   AST_GROUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (load || addr_out[AW-1:BW] == $past(addr_in[AW-1:BW])));   // R10
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
   parameter int AW    = 8,
   parameter int LANES = 2,
   parameter int LW    = 9
) (
   input  logic                clk,
   input  logic [LANES-1:0]    we,
   input  logic [AW-1:0]       waddr,
   input  logic [LANES*LW-1:0] wdata,
   input  logic [AW-1:0]       raddr,
   output logic [LANES*LW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (LW < 1) begin : g_bad_lw
      $error("sbs_array: LW must be at least 1");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we[g]) mem[waddr] <= wdata[g*LW +: LW];
      end
      assign rdata[g*LW +: LW] = mem[raddr];
   end
endmodule

// File: rtl/sbs_outpipe.sv
module sbs_outpipe #(
   parameter int AW = 8,
   parameter int DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue_rd,
   input  logic          is_wr,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] arr_q,
   output logic [DW-1:0] dq,
   output logic          drv
);
   logic rd_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_addr <= '0;
         dq      <= '0;
         drv     <= 1'b0;
      end else begin
         drv     <= is_wr ? 1'b0 : rd_pend;
         if (rd_pend)  dq      <= arr_q;
         rd_pend <= issue_rd;
         if (issue_rd) rd_addr <= addr;
      end
   end

   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |=> !drv);                                                    // R6
   AST_READ_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(issue_rd) && !is_wr) |=> drv);                               // R1
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
   import sbs_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int LANES        = 2,
   parameter int LANE_W       = 9,
   parameter int BURST_W      = 2,
   parameter bit LINEAR_ORDER = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_strb_n,
   input  logic                      ctl_strb_n,
   input  logic                      burst_adv_n,
   input  logic                      sel_a_n,
   input  logic                      sel_b,
   input  logic                      sel_c_n,
   input  logic                      wr_all_n,
   input  logic                      wr_lane_n,
   input  logic [LANES-1:0]          lane_pick_n,
   input  logic                      out_en_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [LANES*LANE_W-1:0]   wdata,
   output logic [LANES*LANE_W-1:0]   rdata,
   output logic                      rdata_oe
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W > 12) begin : g_bad_depth
      $error("sync_burst_sram: ADDR_W too large for the model array");
   end

   acc_kind_t          kind;
   logic               load, step, active, drv;
   logic [LANES-1:0]   lane_we;
   logic [ADDR_W-1:0]  acc_addr, rd_addr;
   logic [DATA_W-1:0]  arr_q;

   sbs_ctrl #(.LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .burst_adv_n(burst_adv_n),
      .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_pick_n(lane_pick_n),
      .kind(kind), .load(load), .step(step), .active(active), .lane_we(lane_we)
   );

   sbs_burst #(.AW(ADDR_W), .BW(BURST_W), .LINEAR(LINEAR_ORDER)) u_burst (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .addr_in(addr), .addr_out(acc_addr)
   );

   sbs_array #(.AW(ADDR_W), .LANES(LANES), .LW(LANE_W)) u_array (
      .clk(clk), .we(lane_we), .waddr(acc_addr), .wdata(wdata),
      .raddr(rd_addr), .rdata(arr_q)
   );

   sbs_outpipe #(.AW(ADDR_W), .DW(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .issue_rd(kind == ACC_READ), .is_wr(kind == ACC_WRITE),
      .addr(acc_addr), .rd_addr(rd_addr), .arr_q(arr_q),
      .dq(rdata), .drv(drv)
   );

   assign rdata_oe = drv & ~out_en_n;

   AST_DESEL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ACC_DESEL) |=> ##1 !drv);                                  // R7
   AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !active) |=> !drv);                                        // R8
   AST_CTL_WRITES_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_strb_n && cpu_strb_n && !sel_a_n && sel_b && !sel_c_n && !wr_all_n)
      |-> (&lane_we));                                                    // R4
   AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !drv);                                             // R11
endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_strb_n, ctl_strb_n, burst_adv_n;
   logic        sel_a_n, sel_b, sel_c_n;
   logic        wr_all_n, wr_lane_n;
   logic [1:0]  lane_pick_n;
   logic        out_en_n;
   logic [7:0]  addr;
   logic [17:0] wdata, rdata;
   logic        rdata_oe;

   int errs = 0;
   int checks = 0;
   bit done = 0;
   string cur_tag = "";

   always #2 clk = ~clk;

   sync_burst_sram u0 (
      .clk(clk), .rst_n(rst_n), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
      .burst_adv_n(burst_adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
      .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_pick_n(lane_pick_n),
      .out_en_n(out_en_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   // reference model built from the requirements
   logic [17:0] ref_mem [256];
   bit          m_act, m_rdp, m_drv, m_wr_last, m_desel_last;
   logic [7:0]  m_base, m_rda;
   logic [1:0]  m_cnt;
   logic [17:0] m_data;

   always @(posedge clk) begin
      bit sel, pgo, cgo, wreq, acc, isw, desel;
      logic [7:0] a;
      sel = !sel_a_n && sel_b && !sel_c_n;
      pgo = !cpu_strb_n && !sel_a_n;
      cgo = !ctl_strb_n;
      wreq = !wr_all_n || !wr_lane_n;
      acc = 0; isw = 0; desel = 0; a = '0;
      if (!rst_n) begin
         m_act = 0; m_rdp = 0; m_drv = 0; m_wr_last = 0; m_desel_last = 0;
      end else begin
         if (pgo || cgo) begin
            if (!sel) desel = 1;
            else begin
               m_base = addr; m_cnt = 0; m_act = 1; a = addr; acc = 1;
               isw = !pgo && wreq;
            end
         end else if (m_act) begin
            if (!burst_adv_n) m_cnt = m_cnt + 2'd1;
            a = {m_base[7:2], m_base[1:0] + m_cnt};
            acc = 1; isw = wreq;
         end
         m_drv = isw ? 0 : m_rdp;
         if (m_rdp) m_data = ref_mem[m_rda];
         if (isw) begin
            if (!wr_all_n) ref_mem[a] = wdata;
            else begin
               if (!lane_pick_n[0]) ref_mem[a][8:0]  = wdata[8:0];
               if (!lane_pick_n[1]) ref_mem[a][17:9] = wdata[17:9];
            end
         end
         m_rdp = acc && !isw;
         if (m_rdp) m_rda = a;
         if (desel) m_act = 0;
         m_wr_last = isw;
         m_desel_last = desel;
      end
   end

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic check_cycle();
      bit exp_oe;
      string t;
      exp_oe = m_drv && !out_en_n;
      if (cur_tag != "") t = cur_tag;
      else if (exp_oe) t = "R1";
      else if (m_wr_last) t = "R6";
      else t = "R7";
      chk(t, "rdata_oe", 32'(rdata_oe), 32'(exp_oe));
      if (exp_oe) chk(t, "rdata", 32'(rdata), 32'(m_data));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      check_cycle();
   endtask

   task automatic quiet();
      cpu_strb_n = 1; ctl_strb_n = 1; burst_adv_n = 1;
      sel_a_n = 0; sel_b = 1; sel_c_n = 0;
      wr_all_n = 1; wr_lane_n = 1; lane_pick_n = 2'b11; out_en_n = 0;
   endtask

   function automatic logic [17:0] pat(int a);
      return 18'(a * 18'h2F3 + 18'h1111);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      quiet(); addr = 0; wdata = 0; rst_n = 0;
      @(negedge clk);
      // R11: quiet during and after reset
      cur_tag = "R11";
      repeat (3) tick();
      chk("R11", "rdata_oe in reset", 32'(rdata_oe), 32'd0);
      rst_n = 1;
      repeat (2) tick();
      chk("R11", "rdata_oe after reset", 32'(rdata_oe), 32'd0);

      // R4: fill the whole array with controller-strobe writes
      cur_tag = "R4";
      for (int a = 0; a < 256; a++) begin
         ctl_strb_n = 0; wr_all_n = 0; burst_adv_n = 0;
         addr = 8'(a); wdata = pat(a);
         tick();
      end
      quiet(); ctl_strb_n = 0; sel_b = 0;            // deselect
      cur_tag = "R7"; tick(); quiet(); tick();

      // R8 then R1: read from the deselected state
      ctl_strb_n = 0; addr = 8'h21;
      cur_tag = "R8"; tick();
      chk("R8", "oe first cycle", 32'(rdata_oe), 32'd0);
      quiet(); burst_adv_n = 1;
      cur_tag = "R1"; tick();
      chk("R1", "read data", 32'(rdata), 32'(pat(33)));

      // R7: deselect while driving, data lingers one cycle
      ctl_strb_n = 0; sel_c_n = 1;
      cur_tag = "R7"; tick();
      chk("R7", "oe after deselect edge", 32'(rdata_oe), 32'd1);
      quiet(); cpu_strb_n = 1; sel_a_n = 1; tick();
      chk("R7", "oe one edge later", 32'(rdata_oe), 32'd0);

      // R2: processor strobe with sel_a_n high starts nothing
      cpu_strb_n = 0; sel_a_n = 1; addr = 8'h40;
      cur_tag = "R2"; tick(); tick();
      chk("R2", "no access", 32'(rdata_oe), 32'd0);

      // R3 + R5: processor-strobe write of lane 0 only
      quiet(); cpu_strb_n = 0; addr = 8'h52; wr_all_n = 0; wdata = 18'h3FFFF;
      cur_tag = "R3"; tick();
      quiet(); wr_lane_n = 0; lane_pick_n = 2'b10; wdata = 18'h2AB55;
      tick();
      chk("R6", "oe after write", 32'(rdata_oe), 32'd0);
      quiet(); ctl_strb_n = 0; addr = 8'h52;
      cur_tag = "R5"; tick(); quiet(); tick();
      chk("R5", "lane mask", 32'(rdata), 32'({pat(82)[17:9], 9'h155}));

      // R10: linear burst from low bits 2'b10
      cur_tag = "R10";
      ctl_strb_n = 0; addr = 8'h66; tick();
      quiet(); burst_adv_n = 0;
      for (int i = 0; i < 4; i++) tick();
      chk("R10", "wrap order", 32'(rdata), 32'(pat(8'h65)));

      // R6: write inside an open access while output enable is low
      quiet(); wr_all_n = 0; wdata = pat(8'h66);
      cur_tag = "R6"; tick();
      chk("R6", "forced off", 32'(rdata_oe), 32'd0);
      quiet(); tick(); tick();

      // R9: output enable acts without a clock
      @(negedge clk); #0.5;
      out_en_n = 1; #0.5;
      chk("R9", "oe high", 32'(rdata_oe), 32'd0);
      out_en_n = 0; #0.5;
      chk("R9", "oe low", 32'(rdata_oe), 32'd1);
      @(negedge clk);

      // random traffic
      cur_tag = "";
      for (int n = 0; n < 3000; n++) begin
         cpu_strb_n  = ($urandom % 4) != 0;
         ctl_strb_n  = ($urandom % 4) != 0;
         burst_adv_n = $urandom % 2;
         sel_a_n     = ($urandom % 8) == 0;
         sel_b       = ($urandom % 8) != 0;
         sel_c_n     = ($urandom % 8) == 0;
         wr_all_n    = ($urandom % 4) != 0;
         wr_lane_n   = ($urandom % 3) != 0;
         lane_pick_n = 2'($urandom);
         out_en_n    = ($urandom % 6) == 0;
         addr        = 8'($urandom);
         wdata       = 18'($urandom);
         tick();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule